// File: doc/BRIEF.md
# Bit-Order-Selectable Serial Shift Port

This block is an eight-bit synchronous serial port built around one shift register. Software loads a byte through a parallel write port, issues a start command and reads the received byte back through the same register once the done flag rises. Each transfer moves exactly eight bits out on the data-out line while eight bits come in from the data-in line. A static configuration input picks whether the most significant or the least significant bit travels first.

The shift clock comes either from an internal generator or from the clock pin. A control register bit chooses between the two at run time. The internal generator runs at the instruction rate divided by two, so one serial period is twelve system clocks with the default six-clock instruction cycle. An external clock is brought into the system clock domain through a two-flop synchroniser followed by an edge detector before it moves any data. When serial operation is disabled, the clock pin is reused as a free-running divided clock output taken from a prescaler. The data-in line can also serve as a half-duplex bidirectional data line.

Top module: `sshift_port`

## Requirements
- R1: After reset, `done` is 0, `rd_data` is 0, `sck_o` is 1, `sdo_o` is 1 and `sdio_oe` is 0. The clock source register selects the internal clock, so `sck_oe` is 1 while `cfg_serial_en` is 1.
- R2: With `cfg_lsb_first`=0, the loaded byte is sent bit 7 first down to bit 0. The first bit received ends up in `rd_data[7]`.
- R3: With `cfg_lsb_first`=1, the loaded byte is sent bit 0 first up to bit 7. The first bit received ends up in `rd_data[0]`.
- R4: With the internal clock selected, `sck_o` idles high and has a period of 12 system clocks during a transfer. It makes exactly 8 periods and then stays high with no further transitions until the next start.
- R5: With the external clock selected (`ctl_ext_clk`=1 written while idle), `sck_oe` is 0. The data moves on edges of `sck_i` once they have passed through the synchroniser.
- R6: `done` is cleared by an accepted start. It is still 0 after the seventh rising shift edge, it is set by the eighth, and it stays set until the next accepted start.
- R7: While a transfer is in progress, `start`, `wr_en` and `ctl_we` have no effect. The transfer completes with the received byte, and the clock source is unchanged.
- R8: With `cfg_serial_en`=0, `sck_oe` is 1 and `sck_o` is a divided clock whose period is 6·2^(s+1) system clocks, where s is `cfg_div_sel` limited to 11. In this mode `start` is ignored.
- R9: With `cfg_bidir`=1 and the direction bit `ctl_tx_dir`=1, `sdio_oe` is 1, `sdio_o` carries the outgoing bits and `sdo_o` is held at 1. With `ctl_tx_dir`=0 or `cfg_bidir`=0, `sdio_oe` is 0.
- R10: Outgoing data changes only on a falling shift edge, and incoming data is sampled only on a rising shift edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lsb_first | input | 1 | Static bit order: 0 sends the MSB first, 1 sends the LSB first |
| cfg_serial_en | input | 1 | 1: the clock pin is the serial clock; 0: the pin outputs the divided clock |
| cfg_bidir | input | 1 | 1: the data-in line works as a bidirectional data line |
| cfg_div_sel | input | 4 | Prescaler tap for the divided clock output |
| ctl_we | input | 1 | Write strobe for the control bits (ignored while busy) |
| ctl_ext_clk | input | 1 | Control bit: 1 selects the external shift clock |
| ctl_tx_dir | input | 1 | Control bit: 1 drives the bidirectional line |
| wr_en | input | 1 | Parallel load of the shift register (ignored while busy) |
| wr_data | input | 8 | Parallel load data |
| start | input | 1 | Start a transfer (one-cycle pulse) |
| rd_data | output | 8 | Shift register contents |
| done | output | 1 | Transfer complete flag |
| sck_i | input | 1 | Clock pin input (external shift clock) |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| sdi_i | input | 1 | Data-in / bidirectional line input |
| sdo_o | output | 1 | Data-out line |
| sdio_o | output | 1 | Bidirectional line output value |
| sdio_oe | output | 1 | Bidirectional line output enable |

## Verification
The hardest case to reach from the ports is a command arriving in the middle of a transfer. It must be dropped without disturbing either the shift in progress or the clock source. The bench watches the clock pin and, right after the third falling edge, fires `start`, `wr_en` with a different byte and a control write that asks for the external clock, all in the same cycle. It then checks that the transfer still finishes on the internal clock with the expected byte and that the pin remains driven. The external path is tested by driving `sck_i` slowly and sampling only once the synchroniser delay has passed. The ends of the transfer are tested by checking `done` just before and just after the eighth rising edge.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

  // Bit of the shift register presented on the data line for a given order.
  function automatic int unsigned tx_index(input int unsigned width, input logic lsb_first);
    return lsb_first ? 0 : width - 1;
  endfunction

  // Prescaler tap, limited to the highest implemented stage.
  function automatic int unsigned tap_index(input int unsigned sel, input int unsigned taps);
    return (sel >= taps) ? taps - 1 : sel;
  endfunction

  // Half period of the internal shift clock in system clocks:
  // the instruction clock divided by two gives one instruction per half.
  function automatic int unsigned half_cycles(input int unsigned insn_div);
    return insn_div;
  endfunction

endpackage

// File: rtl/sshift_tick.sv
module sshift_tick #(
  parameter int unsigned INSN_DIV = 6,
  parameter int unsigned PRE_W    = 12,
  parameter int unsigned SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             div_clk
);
  import sshift_pkg::*;

  localparam int unsigned CW = (INSN_DIV > 1) ? $clog2(INSN_DIV) : 1;
  localparam int unsigned IW = (PRE_W > 1) ? $clog2(PRE_W) : 1;

  logic [CW-1:0]    ins_cnt;
  logic             insn_tick;
  logic [PRE_W-1:0] pre;
  logic [IW-1:0]    tap;

  assign insn_tick = (ins_cnt == CW'(INSN_DIV - 1));
  assign tap       = IW'(tap_index(int'(div_sel), PRE_W));
  assign div_clk   = pre[tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_cnt <= '0;
      pre     <= '0;
    end else begin
      if (insn_tick) begin
        ins_cnt <= '0;
        pre     <= pre + 1'b1;
      end else begin
        ins_cnt <= ins_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sshift_intclk.sv
module sshift_intclk #(
  parameter int unsigned INSN_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic lvl,
  output logic fall_p,
  output logic rise_p
);
  import sshift_pkg::*;

  localparam int unsigned HALF = half_cycles(INSN_DIV);
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap   = run && (cnt == CW'(HALF - 1));
  assign fall_p = wrap && lvl;
  assign rise_p = wrap && !lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b1;
      cnt <= '0;
    end else if (!run) begin
      lvl <= 1'b1;
      cnt <= '0;
    end else if (wrap) begin
      lvl <= ~lvl;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sshift_extsync.sv
module sshift_extsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  output logic fall_p,
  output logic rise_p
);
  // STAGES synchroniser flops plus one history flop for edge detection.
  logic [STAGES:0] pipe;
  logic            cur;
  logic            prev;

  assign cur    = pipe[STAGES-1];
  assign prev   = pipe[STAGES];
  assign rise_p = cur && !prev;
  assign fall_p = !cur && prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], sck_i};
  end
endmodule

// File: rtl/sshift_core.sv
module sshift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsb_first,
  input  logic              serial_en,
  input  logic              start,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_we,
  input  logic              ctl_ext_clk,
  input  logic              ctl_tx_dir,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic              start_acc,
  output logic              ext_sel,
  output logic              tx_dir,
  output logic              out_bit,
  output logic [DATA_W-1:0] shreg
);
  import sshift_pkg::*;

  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned IW = BW;

  logic [BW-1:0]     bitcnt;
  logic [IW-1:0]     oidx;
  logic              shift_now;
  logic              emit_now;
  logic              last_bit;
  logic [DATA_W-1:0] shifted;

  assign start_acc = start && !busy && serial_en;
  assign shift_now = busy && rise_evt;
  assign emit_now  = busy && fall_evt;
  assign last_bit  = (bitcnt == BW'(DATA_W - 1));
  assign oidx      = IW'(tx_index(DATA_W, lsb_first));
  assign shifted   = lsb_first ? {sdi, shreg[DATA_W-1:1]} : {shreg[DATA_W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      out_bit <= 1'b1;
      ext_sel <= 1'b0;
      tx_dir  <= 1'b0;
    end else begin
      if (start_acc) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        bitcnt <= '0;
      end else if (shift_now) begin
        shreg <= shifted;
        if (last_bit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (wr_en && !busy) begin
        shreg <= wr_data;
      end

      if (emit_now) out_bit <= shreg[oidx];

      if (ctl_we && !busy) begin
        ext_sel <= ctl_ext_clk;
        tx_dir  <= ctl_tx_dir;
      end
    end
  end
endmodule

// File: rtl/sshift_port.sv
module sshift_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned INSN_DIV    = 6,
  parameter int unsigned PRE_W       = 12,
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lsb_first,
  input  logic              cfg_serial_en,
  input  logic              cfg_bidir,
  input  logic [SEL_W-1:0]  cfg_div_sel,
  input  logic              ctl_we,
  input  logic              ctl_ext_clk,
  input  logic              ctl_tx_dir,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdio_o,
  output logic              sdio_oe
);
  logic busy, start_acc, ext_sel, tx_dir, out_bit;
  logic int_lvl, int_fall, int_rise, ext_fall, ext_rise;
  logic fall_evt, rise_evt, run_int, div_clk;

  assign run_int  = busy && !ext_sel;
  assign fall_evt = ext_sel ? ext_fall : int_fall;
  assign rise_evt = ext_sel ? ext_rise : int_rise;

  sshift_tick #(.INSN_DIV(INSN_DIV), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_sel(cfg_div_sel), .div_clk(div_clk)
  );

  sshift_intclk #(.INSN_DIV(INSN_DIV)) u_intclk (
    .clk(clk), .rst_n(rst_n), .run(run_int),
    .lvl(int_lvl), .fall_p(int_fall), .rise_p(int_rise)
  );

  sshift_extsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i),
    .fall_p(ext_fall), .rise_p(ext_rise)
  );

  sshift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .lsb_first(cfg_lsb_first), .serial_en(cfg_serial_en),
    .start(start), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_we(ctl_we), .ctl_ext_clk(ctl_ext_clk), .ctl_tx_dir(ctl_tx_dir),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .sdi(sdi_i),
    .busy(busy), .done(done), .start_acc(start_acc),
    .ext_sel(ext_sel), .tx_dir(tx_dir), .out_bit(out_bit), .shreg(rd_data)
  );

  assign sck_o   = cfg_serial_en ? int_lvl : div_clk;
  assign sck_oe  = cfg_serial_en ? !ext_sel : 1'b1;
  assign sdo_o   = cfg_bidir ? 1'b1 : out_bit;
  assign sdio_o  = out_bit;
  assign sdio_oe = cfg_bidir && tx_dir;
endmodule

// File: rtl/sshift_port_chk.sv
module sshift_port_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic start_acc,
  input logic fall_evt,
  input logic rise_evt,
  input logic out_bit,
  input logic ext_sel,
  input logic ctl_we,
  input logic serial_en,
  input logic sck_o,
  input logic sdio_oe,
  input logic cfg_bidir
);
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_evt && rise_evt)); // R10
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && fall_evt) |=> $stable(out_bit)); // R10
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_en && !busy) |-> sck_o); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_acc) |=> done); // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6
  AST_CLKSEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we) |=> $stable(ext_sel)); // R7
  AST_OE_NEEDS_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> cfg_bidir); // R9
endmodule

bind sshift_port sshift_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .start_acc(start_acc),
  .fall_evt(fall_evt), .rise_evt(rise_evt), .out_bit(out_bit), .ext_sel(ext_sel),
  .ctl_we(ctl_we), .serial_en(cfg_serial_en), .sck_o(sck_o), .sdio_oe(sdio_oe),
  .cfg_bidir(cfg_bidir)
);

// File: tb/sshift_port_bench.sv
module sshift_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_lsb_first = 1'b0, cfg_serial_en = 1'b1, cfg_bidir = 1'b0;
  logic [3:0] cfg_div_sel = 4'd0;
  logic       ctl_we = 1'b0, ctl_ext_clk = 1'b0, ctl_tx_dir = 1'b0;
  logic       wr_en = 1'b0, start = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       done, sck_o, sck_oe, sdo_o, sdio_o, sdio_oe;
  logic       sck_i = 1'b1, sdi_i = 1'b0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sshift_port u_sshift_port (
    .clk(clk), .rst_n(rst_n), .cfg_lsb_first(cfg_lsb_first), .cfg_serial_en(cfg_serial_en),
    .cfg_bidir(cfg_bidir), .cfg_div_sel(cfg_div_sel), .ctl_we(ctl_we), .ctl_ext_clk(ctl_ext_clk),
    .ctl_tx_dir(ctl_tx_dir), .wr_en(wr_en), .wr_data(wr_data), .start(start), .rd_data(rd_data),
    .done(done), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] order_bits(input logic [7:0] b, input logic lsb);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = lsb ? b[i] : b[7-i];
    return r;
  endfunction

  task automatic ctl_write(input logic ext, input logic dir);
    @(negedge clk); ctl_we = 1'b1; ctl_ext_clk = ext; ctl_tx_dir = dir;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic load_and_start(input logic [7:0] tx);
    @(negedge clk); wr_data = tx; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic test_reset();
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(sck_o == 1'b1 && sck_oe == 1'b1, "R1 clock pin", {sck_o, sck_oe}, 3);
    chk(sdo_o == 1'b1 && sdio_oe == 1'b0, "R1 data lines", {sdo_o, sdio_oe}, 2);
  endtask

  task automatic test_divclk(input logic [3:0] sel, input int exp_per);
    int t0, t1, cyc;
    logic prev;
    cfg_serial_en = 1'b0; cfg_div_sel = sel;
    @(negedge clk);
    chk(sck_oe == 1'b1, "R8 divided clock driven", sck_oe, 1);
    t0 = -1; t1 = -1; cyc = 0; prev = sck_o;
    while (t1 < 0 && cyc < 4 * exp_per + 50) begin
      @(negedge clk); cyc++;
      if (!prev && sck_o) begin
        if (t0 < 0) t0 = cyc; else t1 = cyc;
      end
      prev = sck_o;
    end
    chk(t1 - t0 == exp_per, "R8 divided clock period", t1 - t0, exp_per);
  endtask

  task automatic test_start_ignored_when_off();
    cfg_serial_en = 1'b0;
    load_and_start(8'h5A);
    repeat (150) @(negedge clk);
    chk(done == 1'b0, "R8 start ignored, done", done, 0);
    chk(rd_data == 8'h5A, "R8 start ignored, data", rd_data, 8'h5A);
    cfg_serial_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic xfer_int(input logic lsb, input logic [7:0] tx, input logic [7:0] rx,
                          input bit disturb, input string tag);
    logic [7:0] seen;
    int nf, nr, cyc, last_fall, bad_per, moves;
    logic prev;
    bit done_early;
    cfg_lsb_first = lsb;
    seen = '0;
    load_and_start(tx);
    chk(done == 1'b0, {tag, " R6 start clears done"}, done, 0);
    nf = 0; nr = 0; cyc = 0; last_fall = -1; bad_per = 0; done_early = 0;
    prev = sck_o;
    while (nr < 8 && cyc < 3000) begin
      @(negedge clk); cyc++;
      wr_en = 1'b0; ctl_we = 1'b0; start = 1'b0; ctl_ext_clk = 1'b0;
      if (prev && !sck_o) begin
        seen[nf] = cfg_bidir ? sdio_o : sdo_o;
        if (cfg_bidir) chk(sdo_o == 1'b1 && sdio_oe == 1'b1, "R9 bidir drive", {sdo_o, sdio_oe}, 3);
        if (last_fall >= 0 && cyc - last_fall != 12) bad_per++;
        last_fall = cyc;
        sdi_i = lsb ? rx[nf] : rx[7-nf];
        nf++;
        if (disturb && nf == 3) begin
          wr_en = 1'b1; wr_data = ~tx; ctl_we = 1'b1; ctl_ext_clk = 1'b1; start = 1'b1;
        end
      end
      if (!prev && sck_o) begin
        nr++;
        if (nr == 7 && done) done_early = 1;
      end
      prev = sck_o;
    end
    chk(!done_early, {tag, " R6 done not after 7 rises"}, done_early, 0);
    chk(nr == 8 && nf == 8, {tag, " R4 edge count"}, nr * 16 + nf, 8 * 16 + 8);
    chk(bad_per == 0, {tag, " R4 period 12"}, bad_per, 0);
    chk(done == 1'b1, {tag, " R6 done after 8 rises"}, done, 1);
    chk(seen == order_bits(tx, lsb), {tag, " R2 R3 R10 tx order"}, seen, order_bits(tx, lsb));
    chk(rd_data == rx, {tag, " R2 R3 R10 rx data"}, rd_data, rx);
    moves = 0; prev = sck_o;
    repeat (40) begin
      @(negedge clk);
      if (sck_o != prev || !sck_o) moves++;
      prev = sck_o;
    end
    chk(moves == 0, {tag, " R4 clock stopped high"}, moves, 0);
    chk(done == 1'b1, {tag, " R6 done held"}, done, 1);
    if (disturb) chk(sck_oe == 1'b1, {tag, " R7 clock source unchanged"}, sck_oe, 1);
  endtask

  task automatic xfer_ext(input logic lsb, input logic [7:0] tx, input logic [7:0] rx, input string tag);
    logic [7:0] seen;
    cfg_lsb_first = lsb;
    seen = '0;
    ctl_write(1'b1, 1'b0);
    chk(sck_oe == 1'b0, {tag, " R5 pin released"}, sck_oe, 0);
    load_and_start(tx);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b0;
      sdi_i = lsb ? rx[i] : rx[7-i];
      repeat (8) @(negedge clk);
      seen[i] = sdo_o;
      if (i == 7) chk(done == 1'b0, {tag, " R6 done not after 7 rises"}, done, 0);
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
    end
    chk(done == 1'b1, {tag, " R5 R6 done"}, done, 1);
    chk(seen == order_bits(tx, lsb), {tag, " R5 tx order"}, seen, order_bits(tx, lsb));
    chk(rd_data == rx, {tag, " R5 rx data"}, rd_data, rx);
    ctl_write(1'b0, 1'b0);
  endtask

  task automatic test_bidir();
    cfg_bidir = 1'b1;
    ctl_write(1'b0, 1'b1);
    chk(sdio_oe == 1'b1, "R9 oe with tx direction", sdio_oe, 1);
    xfer_int(1'b1, 8'h94, 8'h2D, 1'b0, "bidir");
    ctl_write(1'b0, 1'b0);
    chk(sdio_oe == 1'b0, "R9 oe with rx direction", sdio_oe, 0);
    ctl_write(1'b0, 1'b1);
    cfg_bidir = 1'b0;
    @(negedge clk);
    chk(sdio_oe == 1'b0, "R9 oe with bidir off", sdio_oe, 0);
    ctl_write(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_start_ignored_when_off();
    test_divclk(4'd0, 12);
    test_divclk(4'd3, 96);
    cfg_serial_en = 1'b1;
    repeat (2) @(negedge clk);
    xfer_int(1'b0, 8'hC6, 8'h3B, 1'b0, "int msb");
    xfer_int(1'b1, 8'hC6, 8'h3B, 1'b0, "int lsb");
    xfer_ext(1'b0, 8'h1E, 8'hD2, "ext msb");
    xfer_ext(1'b1, 8'h1E, 8'hD2, "ext lsb");
    xfer_int(1'b0, 8'hA3, 8'h71, 1'b1, "R7 busy commands");
    test_bidir();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule